// File: doc/BRIEF.md
# Lock-Protected System Control Registers

This block is the register file of a processor module's system controller. It sits on a simple 32-bit register port. A read returns data in the same cycle. A write takes effect at the next rising clock edge.

The block holds:
- a fixed identification word and a fixed status word;
- two oscillator setting words, which software can change only after it has written a magic key;
- an SDRAM setting word;
- an init word that drives a memory-remap output and an LED output;
- volatile and non-volatile flag words, each with its own set and clear address;
- a small interrupt source with separate normal and fast enable masks.

Level bit 0 of the interrupt source is the only bit software can drive. A write to the control address can also request a one-cycle board-reset pulse. The normal and fast interrupt request outputs come from registers.

Software first writes 0xA05F to the key address. It then writes the oscillator words. Finally it writes any other value to the key address, which locks them again. Voltage control, clock synthesis and the memory-size serial ROM are not modelled, so their addresses read as zero.

Top module: `sysctl_regs`

## Requirements
- R1: A read of offset 0x00 returns 0x411A3001, and a read of offset 0x10 returns 0x00100000.
- R2: A write to the key word at 0x14 keeps only bits 15:0. A read of 0x14 returns 0x0001A05F while the stored key is 0xA05F, and the stored key zero-extended otherwise.
- R3: The oscillator word (0x08) and the auxiliary oscillator word (0x1C) take a write only while the stored key is 0xA05F. At any other time the write leaves them unchanged.
- R4: After reset the words read as follows:
  - oscillator 0x01000048;
  - auxiliary oscillator 0x0007FEFF;
  - init (0x24) 0x00000112;
  - SDRAM (0x20) 0x00011122 ORed with SIZE_CODE shifted into bits 4:2 (0x0001112A for the default SIZE_CODE of 2);
  - key, both flag words and both enable masks zero.
- R5: A write to 0x30 ORs the data into the flags word, and a write to 0x34 clears every flag bit that is 1 in the data. Offsets 0x38 and 0x3C do the same for the non-volatile flags. Reads of 0x30 and 0x38 return the current words.
- R6: A write to 0x48 ORs the data into the normal enable mask, and a write to 0x4C clears the bits that are 1 in the data. Offsets 0x68 and 0x6C do the same for the fast mask. Reads behave as follows:
  - 0x48 and 0x68 return the masks;
  - 0x44 and 0x64 return the raw level;
  - 0x40 returns the level AND the normal mask;
  - 0x60 returns the level AND the fast mask.
- R7: A write to 0x50 with data bit 0 at 1 sets level bit 0. A write to 0x54 with data bit 0 at 1 clears it. A write with data bit 0 at 0 has no effect. A read of 0x50 returns level bit 0.
- R8: A write to the control address 0x0C with data bit 3 at 1 drives rstPulse high for exactly the one cycle after the write. The same write copies data bits 2 and 0 into init bits 2 and 0. The output remapOut follows init bit 2, and ledOut follows init bit 0.
- R9: irqOut is high one cycle after (level AND normal mask) is non-zero, and fiqOut is high one cycle after (level AND fast mask) is non-zero. Both fall one cycle after their condition clears.
- R10: A read of any unmapped offset, or of the write-only offsets 0x0C, 0x34, 0x3C, 0x4C, 0x54 and 0x6C, returns zero. A write to an unmapped or read-only offset changes no state.
- R11: The SDRAM word (0x20) and the init word (0x24) store a full 32-bit write and read it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access this cycle |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle while sel is high |
| irqOut | output | 1 | Normal interrupt request, registered |
| fiqOut | output | 1 | Fast interrupt request, registered |
| remapOut | output | 1 | Memory-remap select (init bit 2) |
| ledOut | output | 1 | LED drive (init bit 0) |
| rstPulse | output | 1 | One-cycle board-reset request |

## Verification
Results arrive at fixed delays after a stimulus:
- Read data is combinational, so a read is due in the same cycle as its address.
- A write changes the register state, remapOut, ledOut and rstPulse at the first rising edge after it is driven.
- irqOut and fiqOut follow one edge after that.

The bench drives inputs on falling edges and samples one time unit later. It checks state and the pin outputs at the first falling edge after a write. It checks the interrupt pins once at that falling edge, where they must still hold their old value, and again at the next falling edge. It checks rstPulse high at the first falling edge and low at the second.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] KEY_OPEN   = 32'h0001_A05F;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ID, SEL_OSC, SEL_STAT, SEL_KEY, SEL_AUX, SEL_SDRAM,
    SEL_INIT, SEL_FLAGS, SEL_NV, SEL_IRQSTAT, SEL_IRQRAW, SEL_IRQEN,
    SEL_SOFT, SEL_FIQSTAT, SEL_FIQRAW, SEL_FIQEN
  } regSel_e;

  typedef struct packed {
    logic wrOsc;
    logic wrCtrl;
    logic wrKey;
    logic wrAux;
    logic wrSdram;
    logic wrInit;
    logic flagSet;
    logic flagClr;
    logic nvSet;
    logic nvClr;
    logic irqEnSet;
    logic irqEnClr;
    logic fiqEnSet;
    logic fiqEnClr;
    logic softSet;
    logic softClr;
  } strobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regSel_e           rdSel,
  output strobe_t           stb
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              isWr;
  logic              isRd;

  assign wordIdx = addr[ADDR_W-1:2];
  assign isWr    = sel & wrEn;
  assign isRd    = sel & ~wrEn;

  function automatic logic hit(input logic [WIDX_W-1:0] idx, input int byteOff);
    return idx == WIDX_W'(byteOff / 4);
  endfunction

  always_comb begin
    rdSel = SEL_NONE;
    if (isRd) begin
      if      (hit(wordIdx, 'h00)) rdSel = SEL_ID;
      else if (hit(wordIdx, 'h08)) rdSel = SEL_OSC;
      else if (hit(wordIdx, 'h10)) rdSel = SEL_STAT;
      else if (hit(wordIdx, 'h14)) rdSel = SEL_KEY;
      else if (hit(wordIdx, 'h1C)) rdSel = SEL_AUX;
      else if (hit(wordIdx, 'h20)) rdSel = SEL_SDRAM;
      else if (hit(wordIdx, 'h24)) rdSel = SEL_INIT;
      else if (hit(wordIdx, 'h30)) rdSel = SEL_FLAGS;
      else if (hit(wordIdx, 'h38)) rdSel = SEL_NV;
      else if (hit(wordIdx, 'h40)) rdSel = SEL_IRQSTAT;
      else if (hit(wordIdx, 'h44)) rdSel = SEL_IRQRAW;
      else if (hit(wordIdx, 'h48)) rdSel = SEL_IRQEN;
      else if (hit(wordIdx, 'h50)) rdSel = SEL_SOFT;
      else if (hit(wordIdx, 'h60)) rdSel = SEL_FIQSTAT;
      else if (hit(wordIdx, 'h64)) rdSel = SEL_FIQRAW;
      else if (hit(wordIdx, 'h68)) rdSel = SEL_FIQEN;
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrOsc    = isWr & hit(wordIdx, 'h08);
    stb.wrCtrl   = isWr & hit(wordIdx, 'h0C);
    stb.wrKey    = isWr & hit(wordIdx, 'h14);
    stb.wrAux    = isWr & hit(wordIdx, 'h1C);
    stb.wrSdram  = isWr & hit(wordIdx, 'h20);
    stb.wrInit   = isWr & hit(wordIdx, 'h24);
    stb.flagSet  = isWr & hit(wordIdx, 'h30);
    stb.flagClr  = isWr & hit(wordIdx, 'h34);
    stb.nvSet    = isWr & hit(wordIdx, 'h38);
    stb.nvClr    = isWr & hit(wordIdx, 'h3C);
    stb.irqEnSet = isWr & hit(wordIdx, 'h48);
    stb.irqEnClr = isWr & hit(wordIdx, 'h4C);
    stb.softSet  = isWr & hit(wordIdx, 'h50);
    stb.softClr  = isWr & hit(wordIdx, 'h54);
    stb.fiqEnSet = isWr & hit(wordIdx, 'h68);
    stb.fiqEnClr = isWr & hit(wordIdx, 'h6C);
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int         IRQ_W     = 8,
  parameter logic [2:0] SIZE_CODE = 3'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regSel_e          rdSel,
  input  strobe_t          stb,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             irqOut,
  output logic             fiqOut,
  output logic             remapOut,
  output logic             ledOut,
  output logic             rstPulse,
  output logic [15:0]      keyQ,
  output logic [31:0]      oscQ,
  output logic [31:0]      auxQ,
  output logic [IRQ_W-1:0] levelQ,
  output logic [IRQ_W-1:0] irqEnQ,
  output logic [IRQ_W-1:0] fiqEnQ
);

  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | (32'(SIZE_CODE) << 2);
  localparam int          NMASK     = 2;

  logic [31:0]      sdramQ;
  logic [31:0]      initQ;
  logic [31:0]      flagsQ;
  logic [31:0]      nvQ;
  logic             softQ;
  logic             unlocked;
  logic [IRQ_W-1:0] maskQ   [NMASK];
  logic [NMASK-1:0] maskSet;
  logic [NMASK-1:0] maskClr;
  logic [NMASK-1:0] reqNext;

  assign unlocked = (keyQ == UNLOCK_KEY);
  assign levelQ   = {{(IRQ_W-1){1'b0}}, softQ};

  // Key and the two lock-guarded oscillator words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ <= '0;
      oscQ <= OSC_RST;
      auxQ <= AUX_RST;
    end else begin
      if (stb.wrKey)             keyQ <= wdata[15:0];
      if (stb.wrOsc && unlocked) oscQ <= wdata;
      if (stb.wrAux && unlocked) auxQ <= wdata;
    end
  end

  // Plain words, init/control and reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdramQ   <= SDRAM_RST;
      initQ    <= INIT_RST;
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= stb.wrCtrl & wdata[3];
      if (stb.wrSdram) sdramQ <= wdata;
      if (stb.wrInit) begin
        initQ <= wdata;
      end else if (stb.wrCtrl) begin
        initQ[2] <= wdata[2];
        initQ[0] <= wdata[0];
      end
    end
  end

  assign remapOut = initQ[2];
  assign ledOut   = initQ[0];

  // Set/clear flag words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      nvQ    <= '0;
    end else begin
      if (stb.flagSet)      flagsQ <= flagsQ | wdata;
      else if (stb.flagClr) flagsQ <= flagsQ & ~wdata;
      if (stb.nvSet)        nvQ    <= nvQ | wdata;
      else if (stb.nvClr)   nvQ    <= nvQ & ~wdata;
    end
  end

  // Software level bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softQ <= 1'b0;
    end else if (stb.softSet && wdata[0]) begin
      softQ <= 1'b1;
    end else if (stb.softClr && wdata[0]) begin
      softQ <= 1'b0;
    end
  end

  // Enable masks (index 0 normal, index 1 fast) and registered requests
  assign maskSet = {stb.fiqEnSet, stb.irqEnSet};
  assign maskClr = {stb.fiqEnClr, stb.irqEnClr};

  for (genvar k = 0; k < NMASK; k++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[k] <= '0;
      end else if (maskSet[k]) begin
        maskQ[k] <= maskQ[k] | wdata[IRQ_W-1:0];
      end else if (maskClr[k]) begin
        maskQ[k] <= maskQ[k] & ~wdata[IRQ_W-1:0];
      end
    end
    assign reqNext[k] = |(levelQ & maskQ[k]);
  end

  assign irqEnQ = maskQ[0];
  assign fiqEnQ = maskQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= reqNext[0];
      fiqOut <= reqNext[1];
    end
  end

  // Read multiplexer
  always_comb begin
    unique case (rdSel)
      SEL_ID:      rdata = ID_WORD;
      SEL_OSC:     rdata = oscQ;
      SEL_STAT:    rdata = STAT_WORD;
      SEL_KEY:     rdata = unlocked ? KEY_OPEN : {16'h0, keyQ};
      SEL_AUX:     rdata = auxQ;
      SEL_SDRAM:   rdata = sdramQ;
      SEL_INIT:    rdata = initQ;
      SEL_FLAGS:   rdata = flagsQ;
      SEL_NV:      rdata = nvQ;
      SEL_IRQSTAT: rdata = 32'(levelQ & irqEnQ);
      SEL_IRQRAW:  rdata = 32'(levelQ);
      SEL_IRQEN:   rdata = 32'(irqEnQ);
      SEL_SOFT:    rdata = {31'h0, softQ};
      SEL_FIQSTAT: rdata = 32'(levelQ & fiqEnQ);
      SEL_FIQRAW:  rdata = 32'(levelQ);
      SEL_FIQEN:   rdata = 32'(fiqEnQ);
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         IRQ_W     = 8,
  parameter logic [2:0] SIZE_CODE = 3'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              remapOut,
  output logic              ledOut,
  output logic              rstPulse
);

  regSel_e          rdSel;
  strobe_t          stb;
  logic [15:0]      keyQ;
  logic [31:0]      oscQ;
  logic [31:0]      auxQ;
  logic [IRQ_W-1:0] levelQ;
  logic [IRQ_W-1:0] irqEnQ;
  logic [IRQ_W-1:0] fiqEnQ;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .sel   (sel),
    .wrEn  (wrEn),
    .addr  (addr),
    .rdSel (rdSel),
    .stb   (stb)
  );

  sysctl_dp #(.IRQ_W(IRQ_W), .SIZE_CODE(SIZE_CODE)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .rdSel    (rdSel),
    .stb      (stb),
    .wdata    (wdata),
    .rdata    (rdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .remapOut (remapOut),
    .ledOut   (ledOut),
    .rstPulse (rstPulse),
    .keyQ     (keyQ),
    .oscQ     (oscQ),
    .auxQ     (auxQ),
    .levelQ   (levelQ),
    .irqEnQ   (irqEnQ),
    .fiqEnQ   (fiqEnQ)
  );

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk #(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irqOut,
  input logic              fiqOut,
  input logic              rstPulse,
  input logic [15:0]       keyQ,
  input logic [31:0]       oscQ,
  input logic [31:0]       auxQ,
  input logic [IRQ_W-1:0]  levelQ,
  input logic [IRQ_W-1:0]  irqEnQ,
  input logic [IRQ_W-1:0]  fiqEnQ
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wIdx;
  assign wIdx = addr[ADDR_W-1:2];

  a_r1_id_word: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !wrEn && wIdx == WIDX_W'(0)) |-> rdata == 32'h411A_3001);

  a_r2_key_low_half: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && wIdx == WIDX_W'(5)) |=> keyQ == $past(wdata[15:0]));

  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && wIdx == WIDX_W'(2) && keyQ != 16'hA05F) |=> $stable(oscQ));

  a_r3_aux_locked: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && wIdx == WIDX_W'(7) && keyQ != 16'hA05F) |=> $stable(auxQ));

  a_r8_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && wIdx == WIDX_W'(3) && wdata[3]) |=> rstPulse);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> $past(sel && wrEn && wIdx == WIDX_W'(3)));

  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rstN)
    (|(levelQ & irqEnQ)) |=> irqOut);

  a_r9_fiq_follow: assert property (@(posedge clk) disable iff (!rstN)
    (|(levelQ & fiqEnQ)) |=> fiqOut);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|(levelQ & irqEnQ)) |=> !irqOut);

endmodule

bind sysctl_regs sysctl_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sel      (sel),
  .wrEn     (wrEn),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irqOut   (irqOut),
  .fiqOut   (fiqOut),
  .rstPulse (rstPulse),
  .keyQ     (keyQ),
  .oscQ     (oscQ),
  .auxQ     (auxQ),
  .levelQ   (levelQ),
  .irqEnQ   (irqEnQ),
  .fiqEnQ   (fiqEnQ)
);

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irqOut, fiqOut, remapOut, ledOut, rstPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_regs u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqOut(irqOut), .fiqOut(fiqOut),
    .remapOut(remapOut), .ledOut(ledOut), .rstPulse(rstPulse)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0, 8'h00, 32'h411A3001, 8'd1},  // R1 id
    '{1'b0, 8'h00, 32'h0, 8'h10, 32'h00100000, 8'd1},  // R1 status
    '{1'b0, 8'h00, 32'h0, 8'h08, 32'h01000048, 8'd4},  // R4 osc reset
    '{1'b0, 8'h00, 32'h0, 8'h1C, 32'h0007FEFF, 8'd4},  // R4 aux reset
    '{1'b0, 8'h00, 32'h0, 8'h24, 32'h00000112, 8'd4},  // R4 init reset
    '{1'b0, 8'h00, 32'h0, 8'h20, 32'h0001112A, 8'd4},  // R4 sdram reset
    '{1'b1, 8'h08, 32'hDEADBEEF, 8'h08, 32'h01000048, 8'd3}, // R3 locked
    '{1'b1, 8'h14, 32'h1234A05F, 8'h14, 32'h0001A05F, 8'd2}, // R2 unlock
    '{1'b1, 8'h08, 32'hDEADBEEF, 8'h08, 32'hDEADBEEF, 8'd3}, // R3 open
    '{1'b1, 8'h1C, 32'h00000055, 8'h1C, 32'h00000055, 8'd3}, // R3 open aux
    '{1'b1, 8'h14, 32'h0000BEEF, 8'h14, 32'h0000BEEF, 8'd2}, // R2 relock
    '{1'b1, 8'h1C, 32'h11111111, 8'h1C, 32'h00000055, 8'd3}, // R3 locked aux
    '{1'b1, 8'h30, 32'h000000F0, 8'h30, 32'h000000F0, 8'd5}, // R5 set
    '{1'b1, 8'h34, 32'h00000030, 8'h30, 32'h000000C0, 8'd5}, // R5 clear
    '{1'b1, 8'h38, 32'h0000000F, 8'h38, 32'h0000000F, 8'd5}, // R5 nv set
    '{1'b1, 8'h3C, 32'h00000001, 8'h38, 32'h0000000E, 8'd5}, // R5 nv clear
    '{1'b1, 8'h48, 32'h000000A5, 8'h48, 32'h000000A5, 8'd6}, // R6 irq en set
    '{1'b1, 8'h4C, 32'h00000005, 8'h48, 32'h000000A0, 8'd6}, // R6 irq en clr
    '{1'b1, 8'h68, 32'h00000003, 8'h68, 32'h00000003, 8'd6}, // R6 fiq en set
    '{1'b1, 8'h50, 32'h00000001, 8'h44, 32'h00000001, 8'd7}, // R7 soft set
    '{1'b0, 8'h00, 32'h0, 8'h40, 32'h00000000, 8'd6},        // R6 masked status
    '{1'b0, 8'h00, 32'h0, 8'h60, 32'h00000001, 8'd6},        // R6 fiq status
    '{1'b1, 8'h54, 32'h00000000, 8'h50, 32'h00000001, 8'd7}, // R7 bit0 zero
    '{1'b1, 8'h54, 32'h00000001, 8'h50, 32'h00000000, 8'd7}, // R7 clear
    '{1'b1, 8'h20, 32'h12345678, 8'h20, 32'h12345678, 8'd11},// R11 sdram
    '{1'b1, 8'h80, 32'hFFFFFFFF, 8'h80, 32'h00000000, 8'd10},// R10 unmapped
    '{1'b1, 8'h00, 32'hFFFFFFFF, 8'h00, 32'h411A3001, 8'd10},// R10 read-only
    '{1'b0, 8'h00, 32'h0, 8'h0C, 32'h00000000, 8'd10}        // R10 ctrl reads 0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; wrEn = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R9 R8 outputs at reset
    check("R9 irq reset", {31'h0, irqOut}, 32'h0);
    check("R9 fiq reset", {31'h0, fiqOut}, 32'h0);
    check("R8 remap reset", {31'h0, remapOut}, 32'h0);
    check("R8 led reset", {31'h0, ledOut}, 32'h0);
    check("R8 pulse reset", {31'h0, rstPulse}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) doWrite(VEC[i].wa, VEC[i].wd);
      else @(negedge clk);
      doRead(VEC[i].ra, rd);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), rd, VEC[i].ex);
    end

    // R9: normal mask now 0xA0, fast mask 0x03, level 0
    doWrite(8'h48, 32'h1);
    doWrite(8'h50, 32'h1);
    #1;
    check("R9 irq not yet", {31'h0, irqOut}, 32'h0);
    @(negedge clk); #1;
    check("R9 irq raised", {31'h0, irqOut}, 32'h1);
    check("R9 fiq raised", {31'h0, fiqOut}, 32'h1);
    doWrite(8'h4C, 32'h1);
    #1;
    check("R9 irq held", {31'h0, irqOut}, 32'h1);
    @(negedge clk); #1;
    check("R9 irq dropped", {31'h0, irqOut}, 32'h0);
    check("R9 fiq stays", {31'h0, fiqOut}, 32'h1);

    // R8 control
    doWrite(8'h0C, 32'h5);
    #1;
    check("R8 remap set", {31'h0, remapOut}, 32'h1);
    check("R8 led set", {31'h0, ledOut}, 32'h1);
    check("R8 no pulse", {31'h0, rstPulse}, 32'h0);
    doRead(8'h24, rd);
    check("R8 init bits", rd, 32'h117);
    doWrite(8'h0C, 32'h8);
    #1;
    check("R8 pulse high", {31'h0, rstPulse}, 32'h1);
    check("R8 remap clear", {31'h0, remapOut}, 32'h0);
    @(negedge clk); #1;
    check("R8 pulse one cycle", {31'h0, rstPulse}, 32'h0);

    // R11 init full write
    doWrite(8'h24, 32'hCAFE0004);
    doRead(8'h24, rd);
    check("R11 init write", rd, 32'hCAFE0004);
    check("R8 remap from init", {31'h0, remapOut}, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule